// File: doc/BRIEF.md
# One-Shot Pulse Generator with Selectable Width

This block turns a single accepted trigger request into one high pulse whose length is one of four decade-spaced durations. A 2-bit width code chosen at the moment of acceptance picks the length. At the nominal 10 MHz clock (100 ns per cycle) these lengths are 1 µs, 10 µs, 100 µs and 1 ms. Between requests the output rests low, whatever the width code does.

Requests use a valid/ready handshake. The block holds `trig_ready` high while it is idle and takes a request on a rising clock edge where `trig_valid` and `trig_ready` are both high. The width is loaded into a 14-bit down-counter on that edge, so later changes on `sel` do not affect the pulse already running. While the pulse is high, `busy_o` is high and `trig_ready` is low. One cycle of `done_o` marks the end of the pulse. The reset is asynchronous and active-low on assertion, and its release passes through a two-stage synchronizer.

Top module: `pulse_oneshot`

## Requirements
- R1: While `rst_n` is low, `pulse_o`, `busy_o`, `done_o` and `trig_ready` are low, and lowering `rst_n` forces `pulse_o` low at once, even in the middle of a pulse. After `rst_n` rises, `trig_ready` stays low for the first rising edge and goes high after the second.
- R2: A request is accepted on a rising edge where `trig_valid` and `trig_ready` are both high. `pulse_o` is high in the cycle that follows that edge.
- R3: Width code `sel` = 2'b00 gives a pulse that is high for exactly 10 clock cycles.
- R4: Width code `sel` = 2'b01 gives a pulse that is high for exactly 100 clock cycles.
- R5: Width code 2'b10 gives exactly 1000 high cycles, and width code 2'b11 gives exactly 10000 high cycles.
- R6: The width comes only from the value of `sel` on the accepting edge. Changing `sel` while the pulse is running does not change its length.
- R7: `trig_ready` is low in every cycle in which `pulse_o` is high. A `trig_valid` that is raised during a pulse and dropped before the pulse ends causes no further pulse.
- R8: `busy_o` is high exactly when `pulse_o` is high. `done_o` is high for exactly one cycle, the cycle right after the last high cycle of the pulse.
- R9: If `trig_valid` is held high, each pulse is followed by exactly one low cycle and then the next pulse. Each of those pulses has the full width.
- R10: `pulse_o` rises only after an accepted request. After a pulse ends it stays low for as long as no new request is accepted, even with `sel` held constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 10 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Width code, sampled on the accepting edge |
| trig_valid | input | 1 | Trigger request strobe |
| trig_ready | output | 1 | High when a request can be accepted |
| pulse_o | output | 1 | The one-shot pulse |
| busy_o | output | 1 | High while a pulse is running |
| done_o | output | 1 | One-cycle marker after the pulse falls |

## Verification
The properties assume that `sel` and `trig_valid` are known (never X or Z) and change only away from the rising edge. They also assume that a reset arriving mid-pulse cancels the pulse-width check, because the checker is disabled while `rst_n` is low. The stimulus follows these rules in every test. Inputs are driven only on falling edges, `sel` is always set to one of the four defined codes, and every reset is held for several cycles. Once the reset is released, the stimulus waits until `trig_ready` is high before it makes a request.

// File: rtl/pog_pkg.sv
package pog_pkg;
  localparam int SEL_W   = 2;
  localparam int N_CODES = 1 << SEL_W;

  typedef logic [SEL_W-1:0] code_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HIGH = 1'b1
  } run_state_e;
endpackage

// File: rtl/pog_rst_sync.sv
module pog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pog_width_lut.sv
module pog_width_lut
  import pog_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int WIDTH0 = 10,
  parameter int WIDTH1 = 100,
  parameter int WIDTH2 = 1000,
  parameter int WIDTH3 = 10000
) (
  input  code_t              code,
  output logic [CNT_W-1:0]   load_val
);
  // Terminal count per code is width minus one: the counter runs N-1 .. 0.
  logic [CNT_W-1:0] tbl [N_CODES];

  function automatic int width_of(input int idx);
    case (idx)
      0:       return WIDTH0;
      1:       return WIDTH1;
      2:       return WIDTH2;
      default: return WIDTH3;
    endcase
  endfunction

  for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
    localparam int TERM = width_of(g) - 1;
    assign tbl[g] = TERM[CNT_W-1:0];
  end

  assign load_val = tbl[code];
endmodule

// File: rtl/pog_timer.sv
module pog_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/pog_ctrl.sv
module pog_ctrl
  import pog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_valid,
  input  logic cnt_zero,
  output logic trig_ready,
  output logic load,
  output logic dec_en,
  output logic pulse,
  output logic done
);
  run_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       accept;

  assign trig_ready = rst_n & (state_q == ST_IDLE);
  assign accept     = trig_valid & trig_ready;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_HIGH;
      ST_HIGH: if (cnt_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign load   = accept;
  assign dec_en = (state_q == ST_HIGH) & ~cnt_zero;
  assign pulse  = (state_q == ST_HIGH);
  assign done   = done_q;
endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import pog_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int WIDTH0 = 10,
  parameter int WIDTH1 = 100,
  parameter int WIDTH2 = 1000,
  parameter int WIDTH3 = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       trig_valid,
  output logic       trig_ready,
  output logic       pulse_o,
  output logic       busy_o,
  output logic       done_o
);
  logic             srst_n;
  logic [CNT_W-1:0] load_val;
  logic             load, dec_en, cnt_zero;

  pog_rst_sync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pog_width_lut #(
    .CNT_W(CNT_W), .WIDTH0(WIDTH0), .WIDTH1(WIDTH1),
    .WIDTH2(WIDTH2), .WIDTH3(WIDTH3)
  ) u_lut (
    .code     (sel),
    .load_val (load_val)
  );

  pog_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .trig_valid (trig_valid),
    .cnt_zero   (cnt_zero),
    .trig_ready (trig_ready),
    .load       (load),
    .dec_en     (dec_en),
    .pulse      (pulse_o),
    .done       (done_o)
  );

  pog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (load),
    .load_val (load_val),
    .dec_en   (dec_en),
    .cnt_zero (cnt_zero)
  );

  assign busy_o = pulse_o;
endmodule

// File: rtl/pulse_oneshot_chk.sv
module pulse_oneshot_chk #(
  parameter int CNT_W  = 14,
  parameter int WIDTH0 = 10,
  parameter int WIDTH1 = 100,
  parameter int WIDTH2 = 1000,
  parameter int WIDTH3 = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic       trig_valid,
  input logic       trig_ready,
  input logic       pulse_o,
  input logic       busy_o,
  input logic       done_o
);
  logic [CNT_W:0] run_len_q;
  logic [CNT_W:0] want_len_q;

  function automatic logic [CNT_W:0] want_of(input logic [1:0] c);
    int w;
    case (c)
      2'b00:   w = WIDTH0;
      2'b01:   w = WIDTH1;
      2'b10:   w = WIDTH2;
      default: w = WIDTH3;
    endcase
    return w[CNT_W:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q  <= '0;
      want_len_q <= '0;
    end else begin
      if (trig_valid && trig_ready) want_len_q <= want_of(sel);
      if (pulse_o) run_len_q <= run_len_q + 1'b1;
      else         run_len_q <= '0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !pulse_o && !trig_ready && !done_o); // R1
  AST_ACCEPT_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (trig_valid && trig_ready) |=> pulse_o); // R2
  AST_WIDTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $fell(pulse_o) |-> run_len_q == want_len_q); // R5
  AST_NOT_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) pulse_o |-> !trig_ready); // R7
  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) busy_o == pulse_o); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(pulse_o) |-> done_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_o) |-> $past(trig_valid && trig_ready)); // R10
endmodule

bind pulse_oneshot pulse_oneshot_chk #(
  .CNT_W(CNT_W), .WIDTH0(WIDTH0), .WIDTH1(WIDTH1),
  .WIDTH2(WIDTH2), .WIDTH3(WIDTH3)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .trig_valid (trig_valid),
  .trig_ready (trig_ready),
  .pulse_o    (pulse_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_pulse_oneshot.sv
module sim_pulse_oneshot;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       trig_valid;
  logic       trig_ready, pulse_o, busy_o, done_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pulse_oneshot u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .trig_valid(trig_valid),
    .trig_ready(trig_ready), .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic [15:0] width;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 16'd10},
    '{2'b01, 16'd100},
    '{2'b10, 16'd1000},
    '{2'b11, 16'd10000},
    '{2'b00, 16'd10},
    '{2'b01, 16'd100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise a request at a falling edge, let one rising edge take it, return at the next falling edge.
  task automatic fire(input logic [1:0] s);
    @(negedge clk);
    chk(trig_ready == 1'b1, "R2 ready before request", int'(trig_ready), 1);
    sel = s;
    trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    chk(pulse_o == 1'b1, "R2 pulse after accept", int'(pulse_o), 1);
  endtask

  // Count high cycles from the current falling edge; stop at the first low sample.
  task automatic measure(output int len, output int side_bad);
    len = 0;
    side_bad = 0;
    while (pulse_o && len < 20000) begin
      len++;
      if (trig_ready || done_o || !busy_o) side_bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len, sb;
    rst_n = 1'b0;
    sel = 2'b00;
    trig_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!pulse_o && !busy_o && !done_o, "R1 outputs low in reset", int'(pulse_o|busy_o|done_o), 0);
    chk(!trig_ready, "R1 ready low in reset", int'(trig_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!trig_ready, "R1 ready low one edge after release", int'(trig_ready), 0);
    @(negedge clk);
    chk(trig_ready, "R1 ready high two edges after release", int'(trig_ready), 1);

    // Table walk: R3 R4 R5 R7 R8
    foreach (VECS[i]) begin
      string tag;
      tag = (VECS[i].code == 2'b00) ? "R3" : (VECS[i].code == 2'b01) ? "R4" : "R5";
      fire(VECS[i].code);
      measure(len, sb);
      chk(len == int'(VECS[i].width), {tag, " width"}, len, int'(VECS[i].width));
      chk(sb == 0, "R7 ready low and busy high during pulse", sb, 0);
      chk(done_o == 1'b1, "R8 done after fall", int'(done_o), 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    end

    // R10: no pulse while idle with sel held
    sel = 2'b11;
    sb = 0;
    repeat (40) begin
      @(negedge clk);
      if (pulse_o || done_o) sb++;
    end
    chk(sb == 0, "R10 stays low without request", sb, 0);

    // R6: sel change during pulse has no effect
    fire(2'b01);
    sel = 2'b11;
    measure(len, sb);
    chk(len == 100, "R6 width kept after sel change", len, 100);
    @(negedge clk);

    // R7: request during pulse, dropped before end, is ignored
    fire(2'b10);
    trig_valid = 1'b1;
    sb = 0;
    repeat (50) begin
      @(negedge clk);
      if (!pulse_o || trig_ready) sb++;
    end
    trig_valid = 1'b0;
    chk(sb == 0, "R7 ready low while request held", sb, 0);
    measure(len, sb);
    chk(len + 50 == 1000, "R7 width unaffected", len + 50, 1000);
    sb = 0;
    repeat (30) begin
      @(negedge clk);
      if (pulse_o || done_o) sb++;
    end
    chk(sb == 0, "R7 no extra pulse from ignored request", sb, 0);

    // R9: held request gives back-to-back pulses with one low cycle
    sel = 2'b00;
    trig_valid = 1'b1;
    @(negedge clk);
    measure(len, sb);
    chk(len == 10, "R9 first pulse width", len, 10);
    chk(!pulse_o && done_o, "R9 single low gap", int'(pulse_o), 0);
    @(negedge clk);
    chk(pulse_o, "R9 next pulse after one low cycle", int'(pulse_o), 1);
    measure(len, sb);
    trig_valid = 1'b0;
    chk(len == 10, "R9 second pulse width", len, 10);
    @(negedge clk);
    chk(!pulse_o, "R9 stops when request dropped", int'(pulse_o), 0);

    // R1: reset in mid-pulse forces the output low at once
    fire(2'b11);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!pulse_o && !busy_o, "R1 async clear mid-pulse", int'(pulse_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(trig_ready && !pulse_o, "R1 idle after reset release", int'(pulse_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule